// File: doc/BRIEF.md
# Indirect Register Port for a Two-Channel Serial Controller

This block is the bus-facing register access unit of a two-channel serial controller. The bus carries a single port-select bit, which picks either the control port or the data port of the channel named by a channel-select bit. Most registers are reached in two steps. A control-port write, made while the channel's pointer is zero, loads a register number. It can also carry a command in its upper bits. The next control-port access, read or write, then goes to the numbered register, and the pointer drops back to zero.

Each channel owns a file of sixteen write registers and a sparse set of readable registers. Two write registers are single copies shared by both channels: the interrupt vector and the master control register. The master control register also issues channel and whole-block resets. The pending-interrupt summary is readable only through channel A. The receive, transmit and status paths behind the registers are small stubs. They latch received bytes, track transmit completion, raise interrupt-pending flags and fold the bytes passed in each direction into 4-bit check nibbles, so that every command has a visible effect at the ports.

Top module: `serial_regport`

## Requirements
- R1: After reset both pointers are 0, a control read returns status 0x04 (bit 2 transmit-empty set, all else clear), register 1 reads 0x01 and `irq` is low.
- R2: A control write with pointer 0 sets the pointer to wdata[2:0], plus 8 when wdata[5:3] equals 1. The next control read or write reaches that register, and the pointer is 0 afterwards.
- R3: A control read with pointer 0 returns status register 0 and leaves the pointer at 0.
- R4: The data port is register 8. A write clears status bit 2 until `tx_done`. A read returns the last received byte and clears status bit 0 (receive-full). Data-port accesses leave the pointer unchanged.
- R5: Command field wdata[5:3] of a pointer-0 control write: 2 clears external-event pending, 5 clears transmit pending, 6 clears parity-error (reg 1 bit 4) and overrun (reg 1 bit 5), 7 clears receive pending. Codes 0, 3 and 4 change nothing.
- R6: Field wdata[7:6] of a pointer-0 control write: 1 clears the receive check nibble (reg 10 bits 3:0), 2 clears the transmit check nibble (reg 10 bits 7:4), 3 clears the underrun latch (status bit 6).
- R7: Registers 2 and 9 exist once and can be written through either channel. Register 2 reads back through either channel. `irq` is high only when register 9 bit 3 is set and a pending flag is set.
- R8: A register 9 write with wdata[7:6] = 1 resets channel B, 2 resets channel A, and 3 resets both channels and clears registers 2 and 9. A channel reset also zeroes that channel's pointer.
- R9: Register 3 via channel A reads {00, A rx, A tx, A ext, B rx, B tx, B ext}, from bit 7 down to bit 0. Via channel B it reads 0x00.
- R10: Registers 12, 13 and 15 read back the value written to that channel's own copy. Read registers 4-7, 9, 11 and 14 return 0x00.
- R11: Receive pending is set when a byte arrives with reg 1 bit 4 set. Transmit pending is set on `tx_done` of a pending byte with reg 1 bit 1 set. External pending is set on `ext_evt` with reg 1 bit 0 set.
- R12: A byte arriving while receive-full sets overrun. `rx_perr` sets parity-error. `tx_done` with nothing pending sets underrun. Each check nibble is the XOR of the high and low nibbles of every byte passed in that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_chan | input | 1 | Channel select, 0 = A, 1 = B |
| bus_port | input | 1 | Port select, 0 = control, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read strobe |
| rx_valid | input | 2 | Receive stub: byte arrives (bit 0 = A) |
| rx_data | input | 16 | Receive stub bytes, A in bits 7:0 |
| rx_perr | input | 2 | Receive stub parity flag with the byte |
| tx_done | input | 2 | Transmit stub: shifter finished |
| ext_evt | input | 2 | External status change event |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a channel reset that lands while that channel is part-way through a pointer sequence. Here the pointer must be dropped and must not aim the next access at the stale register. The bench arms channel B's pointer at register 12, issues the reset through channel A, and then shows that B's next control read returns status rather than register 12. A second hard case is the shared and channel-A-only state. Flags are raised on both channels and then read through the opposite channel. Interrupt masking, the command codes that change nothing and each reset code are then applied while those flags are set.

// File: rtl/serial_regport_pkg.sv
// Package: shared widths, register indices, command actions and check fold.
package serial_regport_pkg;
    parameter int BYTE_W  = 8;
    parameter int NUM_REG = 16;
    parameter int NUM_CH  = 2;
    localparam int PTR_W  = $clog2(NUM_REG);

    localparam logic [PTR_W-1:0] IDX_CMD    = 4'd0;
    localparam logic [PTR_W-1:0] IDX_INTCFG = 4'd1;
    localparam logic [PTR_W-1:0] IDX_VEC    = 4'd2;
    localparam logic [PTR_W-1:0] IDX_PEND   = 4'd3;
    localparam logic [PTR_W-1:0] IDX_DATA   = 4'd8;
    localparam logic [PTR_W-1:0] IDX_MASTER = 4'd9;
    localparam logic [PTR_W-1:0] IDX_CHK    = 4'd10;
    localparam logic [PTR_W-1:0] IDX_TCLO   = 4'd12;
    localparam logic [PTR_W-1:0] IDX_TCHI   = 4'd13;
    localparam logic [PTR_W-1:0] IDX_STEN   = 4'd15;

    // Actions decoded from one pointer-0 control write
    typedef struct packed {
        logic point_hi;
        logic clr_ext;
        logic clr_txip;
        logic clr_err;
        logic clr_rxip;
        logic clr_rxchk;
        logic clr_txchk;
        logic clr_undr;
    } cmd_t;

    // XOR fold of a byte into a check nibble
    function automatic logic [3:0] fold_nib(input logic [BYTE_W-1:0] d);
        return d[7:4] ^ d[3:0];
    endfunction
endpackage

// File: rtl/serial_cmd_decode.sv
// Module: serial_cmd_decode
// Splits a pointer-0 control write into the next pointer value and a set of
// clear actions. Assumes en is asserted only for control writes with pointer 0.
module serial_cmd_decode
    import serial_regport_pkg::*;
(
    input  logic              en,
    input  logic [BYTE_W-1:0] wdata,
    output cmd_t              cmd,
    output logic [PTR_W-1:0]  next_ptr
);
    logic [2:0] code_lo;
    logic [1:0] code_hi;

    assign code_lo = wdata[5:3];
    assign code_hi = wdata[7:6];

    // Decode both command fields into individual actions
    always_comb begin
        cmd           = '0;
        cmd.point_hi  = en && (code_lo == 3'd1);
        cmd.clr_ext   = en && (code_lo == 3'd2);
        cmd.clr_txip  = en && (code_lo == 3'd5);
        cmd.clr_err   = en && (code_lo == 3'd6);
        cmd.clr_rxip  = en && (code_lo == 3'd7);
        cmd.clr_rxchk = en && (code_hi == 2'd1);
        cmd.clr_txchk = en && (code_hi == 2'd2);
        cmd.clr_undr  = en && (code_hi == 2'd3);
    end

    // Pointer: low three bits, upper bank selected by the point-high code
    assign next_ptr = {cmd.point_hi, wdata[2:0]};
endmodule

// File: rtl/serial_chan_regs.sv
// Module: serial_chan_regs
// One channel: pointer sequencer, private write-register file, read mux and
// stub receive/transmit/status latches. Assumes at most one of bus access and
// chan_rst matters per cycle (chan_rst wins). Shared registers are stored by
// the parent; this module reports register writes through wr_stb/wr_idx.
module serial_chan_regs
    import serial_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              acc,
    input  logic              we,
    input  logic              port_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] rr2_in,
    input  logic [BYTE_W-1:0] rr3_in,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              tx_done,
    input  logic              ext_evt,
    output logic [BYTE_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr,
    output logic [2:0]        ip,
    output logic              wr_stb,
    output logic [PTR_W-1:0]  wr_idx
);
    logic [BYTE_W-1:0] cfg [NUM_REG];
    logic [BYTE_W-1:0] rx_buf;
    logic              rx_full, tx_empty, undr, perr_q, ovr;
    logic              rx_ip, tx_ip, ext_ip;
    logic [3:0]        rx_chk, tx_chk;
    logic              ctl_acc, reg_wr, reg_rd, cmd_en, data_rd, data_wr;
    logic [PTR_W-1:0]  next_ptr;
    logic [PTR_W-1:0]  rd_idx;
    cmd_t              cmd;

    // Classify the current bus access
    always_comb begin
        ctl_acc = acc && !port_sel;
        cmd_en  = ctl_acc && we && (ptr == IDX_CMD);
        reg_wr  = ctl_acc && we && (ptr != IDX_CMD);
        reg_rd  = ctl_acc && !we && (ptr != IDX_CMD);
        data_rd = (acc && port_sel && !we) || (reg_rd && ptr == IDX_DATA);
        data_wr = (acc && port_sel && we) || (reg_wr && ptr == IDX_DATA);
    end

    serial_cmd_decode u_dec (
        .en       (cmd_en),
        .wdata    (wdata),
        .cmd      (cmd),
        .next_ptr (next_ptr)
    );

    assign wr_stb = reg_wr;
    assign wr_idx = ptr;
    assign ip     = {rx_ip, tx_ip, ext_ip};

    // Pointer: load on pointer-0 write, fall back to 0 after any indexed access
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst)
            ptr <= '0;
        else if (cmd_en)
            ptr <= next_ptr;
        else if (ctl_acc && ptr != IDX_CMD)
            ptr <= '0;
    end

    // Private write-register file (shared and buffer indices skipped)
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            for (int i = 0; i < NUM_REG; i++) cfg[i] <= '0;
        end else if (reg_wr && ptr != IDX_DATA && ptr != IDX_VEC && ptr != IDX_MASTER) begin
            cfg[ptr] <= wdata;
        end
    end

    // Stub datapath latches, then command clears taking precedence
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            rx_buf <= '0; rx_full <= 1'b0; tx_empty <= 1'b1; undr <= 1'b0;
            perr_q <= 1'b0; ovr <= 1'b0; rx_ip <= 1'b0; tx_ip <= 1'b0;
            ext_ip <= 1'b0; rx_chk <= '0; tx_chk <= '0;
        end else begin
            if (rx_valid) begin
                if (rx_full && !data_rd) ovr <= 1'b1;
                rx_buf  <= rx_data;
                rx_full <= 1'b1;
                if (rx_perr) perr_q <= 1'b1;
                if (cfg[IDX_INTCFG][4]) rx_ip <= 1'b1;
                rx_chk <= rx_chk ^ fold_nib(rx_data);
            end else if (data_rd) begin
                rx_full <= 1'b0;
            end
            if (data_wr) begin
                tx_empty <= 1'b0;
                tx_ip    <= 1'b0;
                tx_chk   <= tx_chk ^ fold_nib(wdata);
            end else if (tx_done) begin
                if (tx_empty) undr <= 1'b1;
                else begin
                    tx_empty <= 1'b1;
                    if (cfg[IDX_INTCFG][1]) tx_ip <= 1'b1;
                end
            end
            if (ext_evt && cfg[IDX_INTCFG][0]) ext_ip <= 1'b1;
            if (cmd.clr_ext)   ext_ip <= 1'b0;
            if (cmd.clr_txip)  tx_ip  <= 1'b0;
            if (cmd.clr_err)   begin perr_q <= 1'b0; ovr <= 1'b0; end
            if (cmd.clr_rxip)  rx_ip  <= 1'b0;
            if (cmd.clr_rxchk) rx_chk <= '0;
            if (cmd.clr_txchk) tx_chk <= '0;
            if (cmd.clr_undr)  undr   <= 1'b0;
        end
    end

    // Read mux: data port maps to index 8, control port to the pointer
    always_comb begin
        rd_idx = port_sel ? IDX_DATA : ptr;
        case (rd_idx)
            IDX_CMD:    rdata = {1'b0, undr, 3'b000, tx_empty, 1'b0, rx_full};
            IDX_INTCFG: rdata = {2'b00, ovr, perr_q, 3'b000, tx_empty};
            IDX_VEC:    rdata = rr2_in;
            IDX_PEND:   rdata = rr3_in;
            IDX_DATA:   rdata = rx_buf;
            IDX_CHK:    rdata = {tx_chk, rx_chk};
            IDX_TCLO:   rdata = cfg[IDX_TCLO];
            IDX_TCHI:   rdata = cfg[IDX_TCHI];
            IDX_STEN:   rdata = cfg[IDX_STEN];
            default:    rdata = '0;
        endcase
    end

    // R2: an indexed control access always hands the pointer back to 0
    a_r2_ptr_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_acc && ptr != IDX_CMD && !chan_rst) |=> (ptr == IDX_CMD));

    // R4: data-port traffic never moves the pointer
    a_r4_data_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && port_sel && !chan_rst) |=> (ptr == $past(ptr)));

    // R4: a data-port write leaves the transmitter busy
    a_r4_tx_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && port_sel && we && !chan_rst) |=> !tx_empty);

    // R12: a byte landing on a full unread buffer raises overrun
    a_r12_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full && !data_rd && !chan_rst && !cmd.clr_err) |=> ovr);
endmodule

// File: rtl/serial_regport.sv
// Module: serial_regport
// Top of the indirect register port: two channel instances, the shared vector
// and master registers, reset decoding, pending summary and interrupt output.
// Assumes one bus access per strobe cycle; bus_rdata is combinational.
module serial_regport
    import serial_regport_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_cs,
    input  logic                      bus_we,
    input  logic                      bus_chan,
    input  logic                      bus_port,
    input  logic [BYTE_W-1:0]         bus_wdata,
    output logic [BYTE_W-1:0]         bus_rdata,
    input  logic [NUM_CH-1:0]         rx_valid,
    input  logic [NUM_CH*BYTE_W-1:0]  rx_data,
    input  logic [NUM_CH-1:0]         rx_perr,
    input  logic [NUM_CH-1:0]         tx_done,
    input  logic [NUM_CH-1:0]         ext_evt,
    output logic                      irq
);
    localparam int CH_A = 0;
    localparam int CH_B = 1;

    logic [BYTE_W-1:0] ch_rdata [NUM_CH];
    logic [PTR_W-1:0]  ch_ptr   [NUM_CH];
    logic [PTR_W-1:0]  ch_widx  [NUM_CH];
    logic [2:0]        ch_ip    [NUM_CH];
    logic [NUM_CH-1:0] ch_wstb, ch_rst, ch_acc;
    logic [BYTE_W-1:0] vec_q;
    logic [5:0]        master_q;
    logic [BYTE_W-1:0] rr3;
    logic              wr_vec, wr_master, hw_rst;

    // Route shared-register writes from whichever channel issued them
    always_comb begin
        wr_vec    = 1'b0;
        wr_master = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_wstb[c] && ch_widx[c] == IDX_VEC)    wr_vec    = 1'b1;
            if (ch_wstb[c] && ch_widx[c] == IDX_MASTER) wr_master = 1'b1;
        end
        hw_rst       = wr_master && (bus_wdata[7:6] == 2'b11);
        ch_rst[CH_A] = wr_master && bus_wdata[7];
        ch_rst[CH_B] = wr_master && bus_wdata[6];
    end

    // Shared vector and master registers, cleared by full reset
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst) begin
            vec_q    <= '0;
            master_q <= '0;
        end else begin
            if (wr_vec)    vec_q    <= bus_wdata;
            if (wr_master) master_q <= bus_wdata[5:0];
        end
    end

    // Pending summary, A flags in the upper group
    assign rr3 = {2'b00, ch_ip[CH_A], ch_ip[CH_B]};

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            assign ch_acc[c] = bus_cs && (bus_chan == c[0]);
            serial_chan_regs u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .chan_rst (ch_rst[c]),
                .acc      (ch_acc[c]),
                .we       (bus_we),
                .port_sel (bus_port),
                .wdata    (bus_wdata),
                .rr2_in   (vec_q),
                .rr3_in   ((c == CH_A) ? rr3 : '0),
                .rx_valid (rx_valid[c]),
                .rx_data  (rx_data[c*BYTE_W +: BYTE_W]),
                .rx_perr  (rx_perr[c]),
                .tx_done  (tx_done[c]),
                .ext_evt  (ext_evt[c]),
                .rdata    (ch_rdata[c]),
                .ptr      (ch_ptr[c]),
                .ip       (ch_ip[c]),
                .wr_stb   (ch_wstb[c]),
                .wr_idx   (ch_widx[c])
            );
        end
    endgenerate

    // Read return and interrupt request
    assign bus_rdata = (bus_cs && !bus_we) ? ch_rdata[bus_chan] : '0;
    assign irq       = master_q[3] && ((ch_ip[CH_A] | ch_ip[CH_B]) != 3'b000);

    // R9: the pending summary never leaks out through channel B
    a_r9_rr3_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && bus_chan && !bus_port && ch_ptr[CH_B] == IDX_PEND)
        |-> (bus_rdata == '0));

    // R8: full reset clears both shared registers
    a_r8_hw_clears_shared: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst |=> (vec_q == '0 && master_q == '0));

    // R7: the interrupt line stays low while master enable is off
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_master && !bus_wdata[3] && !hw_rst) |=> !irq);
endmodule

// File: tb/serial_regport_tb.sv
module serial_regport_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_we = 1'b0, bus_chan = 1'b0, bus_port = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_valid = '0, rx_perr = '0, tx_done = '0, ext_evt = '0;
    logic [15:0] rx_data = '0;
    logic        irq;
    int          n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_regport u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_chan(bus_chan), .bus_port(bus_port), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .tx_done(tx_done), .ext_evt(ext_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic acc(input int ch, input bit port, input bit wr,
                       input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        bus_cs = 1'b1; bus_chan = ch[0]; bus_port = port; bus_we = wr; bus_wdata = d;
        #1 q = bus_rdata;
        @(posedge clk);
        #1 bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic ctl_wr(input int ch, input logic [7:0] d);
        logic [7:0] q;
        acc(ch, 1'b0, 1'b1, d, q);
    endtask

    task automatic ctl_rd(input int ch, output logic [7:0] q);
        acc(ch, 1'b0, 1'b0, 8'h00, q);
    endtask

    task automatic wr_reg(input int ch, input int r, input logic [7:0] v);
        ctl_wr(ch, r[7:0]);
        ctl_wr(ch, v);
    endtask

    task automatic rd_reg(input int ch, input int r, output logic [7:0] q);
        ctl_wr(ch, r[7:0]);
        ctl_rd(ch, q);
    endtask

    task automatic stub(input int ch, input int kind, input logic [7:0] d, input bit pe);
        @(negedge clk);
        case (kind)
            0: begin rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = d; rx_perr[ch] = pe; end
            1: tx_done[ch] = 1'b1;
            default: ext_evt[ch] = 1'b1;
        endcase
        @(posedge clk);
        #1 rx_valid = '0; rx_perr = '0; tx_done = '0; ext_evt = '0;
    endtask

    function automatic logic [7:0] exp_sweep(input int ch, input int r);
        case (r)
            0: return 8'h04;
            1: return 8'h01;
            2: return 8'h66;
            12: return (ch == 0) ? 8'h5A : 8'h11;
            13: return (ch == 0) ? 8'hA5 : 8'h22;
            15: return (ch == 0) ? 8'h3C : 8'h44;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R3: reset state
        for (int ch = 0; ch < 2; ch++) begin
            ctl_rd(ch, q); check("R1 status after reset", q, 8'h04);
            ctl_rd(ch, q); check("R3 pointer stays 0", q, 8'h04);
            rd_reg(ch, 1, q); check("R1 reg1 after reset", q, 8'h01);
        end
        check("R1 irq low", {7'd0, irq}, 8'h00);

        // R10 / R2 / R7: full index sweep on both channels
        wr_reg(0, 12, 8'h5A); wr_reg(0, 13, 8'hA5); wr_reg(0, 15, 8'h3C);
        wr_reg(1, 12, 8'h11); wr_reg(1, 13, 8'h22); wr_reg(1, 15, 8'h44);
        wr_reg(1, 2, 8'h66);
        for (int ch = 0; ch < 2; ch++) begin
            for (int r = 0; r < 16; r++) begin
                rd_reg(ch, r, q); check("R10 R2 indexed read", q, exp_sweep(ch, r));
                ctl_rd(ch, q);    check("R2 pointer back to 0", q, 8'h04);
            end
        end

        // R10: write/read pattern sweep on B reg13, A copy untouched
        for (int i = 0; i < 16; i++) begin
            wr_reg(1, 13, 8'(i * 16 + (15 - i)));
            rd_reg(1, 13, q); check("R10 readback", q, 8'(i * 16 + (15 - i)));
        end
        rd_reg(0, 13, q); check("R10 channel independence", q, 8'hA5);

        // R4 / R12 / R6: transmit side
        acc(0, 1'b1, 1'b1, 8'h3C, q);
        ctl_rd(0, q); check("R4 tx busy after data write", q, 8'h00);
        rd_reg(0, 10, q); check("R12 tx check nibble", q, 8'hF0);
        stub(0, 1, 8'h00, 1'b0);
        ctl_rd(0, q); check("R4 tx empty after done", q, 8'h04);
        stub(0, 1, 8'h00, 1'b0);
        ctl_rd(0, q); check("R12 underrun set", q, 8'h44);
        ctl_wr(0, 8'hC0);
        ctl_rd(0, q); check("R6 underrun cleared", q, 8'h04);
        ctl_wr(0, 8'h80);
        rd_reg(0, 10, q); check("R6 tx check cleared", q, 8'h00);

        // R4 / R12 / R5 / R6: receive side
        stub(0, 0, 8'h96, 1'b1);
        ctl_rd(0, q); check("R4 rx full", q, 8'h05);
        rd_reg(0, 1, q); check("R12 parity error", q, 8'h11);
        rd_reg(0, 10, q); check("R12 rx check nibble", q, 8'h0F);
        stub(0, 0, 8'h21, 1'b0);
        rd_reg(0, 1, q); check("R12 overrun", q, 8'h31);
        rd_reg(0, 10, q); check("R12 rx check folded", q, 8'h0C);
        acc(0, 1'b1, 1'b0, 8'h00, q); check("R4 data read", q, 8'h21);
        ctl_rd(0, q); check("R4 rx full cleared, ptr kept", q, 8'h04);
        ctl_wr(0, 8'h30);
        rd_reg(0, 1, q); check("R5 errors cleared", q, 8'h01);
        ctl_wr(0, 8'h40);
        rd_reg(0, 10, q); check("R6 rx check cleared", q, 8'h00);

        // R11 / R9 / R5 / R7: pending flags, channel A
        wr_reg(0, 1, 8'h13);
        wr_reg(1, 9, 8'h08);
        stub(0, 0, 8'h55, 1'b0);
        rd_reg(0, 3, q); check("R11 R9 A rx pending", q, 8'h20);
        check("R7 irq raised", {7'd0, irq}, 8'h01);
        rd_reg(1, 3, q); check("R9 B reads zero", q, 8'h00);
        ctl_wr(0, 8'h38);
        rd_reg(0, 3, q); check("R5 rx pending cleared", q, 8'h00);
        check("R7 irq dropped", {7'd0, irq}, 8'h00);
        acc(0, 1'b1, 1'b1, 8'h01, q);
        stub(0, 1, 8'h00, 1'b0);
        rd_reg(0, 3, q); check("R11 A tx pending", q, 8'h10);
        ctl_wr(0, 8'h28);
        rd_reg(0, 3, q); check("R5 tx pending cleared", q, 8'h00);
        stub(0, 2, 8'h00, 1'b0);
        rd_reg(0, 3, q); check("R11 A ext pending", q, 8'h08);
        ctl_wr(0, 8'h10);
        rd_reg(0, 3, q); check("R5 ext pending cleared", q, 8'h00);

        // R11 / R9: channel B flags seen through A
        wr_reg(1, 1, 8'h13);
        stub(1, 2, 8'h00, 1'b0);
        rd_reg(0, 3, q); check("R9 B ext bit0", q, 8'h01);
        acc(1, 1'b1, 1'b1, 8'h02, q);
        stub(1, 1, 8'h00, 1'b0);
        rd_reg(0, 3, q); check("R9 B tx bit1", q, 8'h03);
        stub(1, 0, 8'h77, 1'b0);
        rd_reg(0, 3, q); check("R9 B rx bit2", q, 8'h07);

        // R5: codes 0, 3, 4 change nothing
        ctl_wr(1, 8'h00); rd_reg(0, 3, q); check("R5 code0 no effect", q, 8'h07);
        ctl_wr(1, 8'h18); rd_reg(0, 3, q); check("R5 code3 no effect", q, 8'h07);
        ctl_wr(1, 8'h20); rd_reg(0, 3, q); check("R5 code4 no effect", q, 8'h07);

        // R7: shared master enable and vector
        wr_reg(0, 9, 8'h00);
        check("R7 irq masked", {7'd0, irq}, 8'h00);
        rd_reg(0, 3, q); check("R7 flags kept while masked", q, 8'h07);
        wr_reg(0, 9, 8'h08);
        check("R7 irq unmasked", {7'd0, irq}, 8'h01);
        wr_reg(0, 2, 8'h77);
        rd_reg(1, 2, q); check("R7 vector via B", q, 8'h77);
        wr_reg(1, 2, 8'h99);
        rd_reg(0, 2, q); check("R7 vector via A", q, 8'h99);

        // R8: channel and full resets
        wr_reg(0, 9, 8'h48);
        rd_reg(0, 3, q); check("R8 B reset clears B flags", q, 8'h00);
        check("R8 irq after B reset", {7'd0, irq}, 8'h00);
        rd_reg(1, 12, q); check("R8 B file cleared", q, 8'h00);
        rd_reg(0, 12, q); check("R8 A file kept", q, 8'h5A);
        ctl_wr(1, 8'h0C);
        wr_reg(0, 9, 8'h40);
        ctl_rd(1, q); check("R8 reset drops armed pointer", q, 8'h04);
        wr_reg(1, 12, 8'h11);
        wr_reg(1, 9, 8'h88);
        rd_reg(0, 12, q); check("R8 A reset clears A file", q, 8'h00);
        rd_reg(1, 12, q); check("R8 B file kept on A reset", q, 8'h11);
        rd_reg(0, 2, q); check("R8 vector kept on channel reset", q, 8'h99);
        wr_reg(0, 9, 8'hC8);
        rd_reg(1, 2, q); check("R8 full reset clears vector", q, 8'h00);
        rd_reg(1, 12, q); check("R8 full reset clears B", q, 8'h00);
        wr_reg(0, 1, 8'h01);
        stub(0, 2, 8'h00, 1'b0);
        check("R8 master cleared by full reset", {7'd0, irq}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule